// File: doc/BRIEF.md
# Soft-Stepping Gain Ramp Controller

This block drives the gain code of a recording amplifier from a programmed gain target. Gain is counted in half-decibel units, so a code runs from 0 (0 dB) to 119 (59.5 dB), and the amplifier also has a separate mute state. With soft-stepping on, the applied gain never jumps: it moves one code per sample strobe, or one code per two strobes, toward the target. A new target given in the middle of a ramp turns the ramp around from wherever it stands.

A soft-step disable input bypasses the ramp, and the applied value follows the target on the next clock. A power-down request replaces the target with mute. The block ramps down through code 0 into mute and then raises a power-down-complete flag, which tells the system that the master clock may be stopped. A settled flag reports that the applied gain has reached the value currently being aimed at.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the block is in mute with gain_o = 0 and pd_done_o low while pwrdn_req_i is low.
- R2: With soft-stepping on and pace_half_i = 0, each sample strobe moves the applied gain exactly one code toward the target, visible on the clock after the strobe.
- R3: With pace_half_i = 1, the gain moves one code on every second strobe of a ramp; the first strobe after the ramp starts does not move it.
- R4: Leaving mute under soft-stepping goes to code 0 first, and mute is entered only from code 0, as one step below it.
- R5: A target change in the middle of a ramp continues from the current applied code without a restart.
- R6: A target code above 119 is treated as 119.
- R7: settled_o is high exactly when the applied state (code and mute) equals the effective target, which is mute during a power-down request and the clamped target code otherwise.
- R8: With bypass_i = 1, the applied state takes the effective target on the next clock, whatever the distance.
- R9: A power-down request ramps the gain down to mute; pd_done_o is high only while the request is held and the block is in mute.
- R10: With soft-stepping on, the applied state does not change on a clock without a sample strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_stb_i | input | 1 | One-clock strobe per sample period |
| tgt_code_i | input | 7 | Programmed gain target in half-decibel units |
| pace_half_i | input | 1 | 1: one step per two strobes, 0: one step per strobe |
| bypass_i | input | 1 | 1: disable soft-stepping, follow target at once |
| pwrdn_req_i | input | 1 | Power-down request, ramps gain to mute |
| gain_o | output | 7 | Applied gain code, 0 while muted |
| mute_o | output | 1 | Applied state is mute |
| settled_o | output | 1 | Applied state equals effective target |
| pd_done_o | output | 1 | Power-down ramp finished, clock may stop |

## Verification
The ramp is driven upward out of mute, downward, and reversed in mid-flight, which separates a step counted from the current value from one restarted at the old origin or target. The same target distance is walked at both pacing rates, so an off-by-one in the half-rate phase shows up as a code one step early or late. A target above the range, a jump under bypass, and a full power-down descent through code 0 into mute tell apart clamping, the immediate path, and the ordering of the done flag against the final step; a reset in the middle of operation confirms the mute state returns.

// File: rtl/gr_pkg.sv
package gr_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } step_dir_e;
endpackage

// File: rtl/gr_target_sel.sv
module gr_target_sel #(
  parameter int GAIN_W   = 7,
  parameter int GAIN_MAX = 119
) (
  input  logic [GAIN_W-1:0] tgt_code_i,
  input  logic              pwrdn_req_i,
  output logic              eff_mute_o,
  output logic [GAIN_W-1:0] eff_code_o
);
  localparam logic [GAIN_W-1:0] MaxCode = GAIN_W'(GAIN_MAX);

  always_comb begin
    eff_mute_o = pwrdn_req_i;
    if (pwrdn_req_i) begin
      eff_code_o = '0;
    end else if (tgt_code_i > MaxCode) begin
      eff_code_o = MaxCode;
    end else begin
      eff_code_o = tgt_code_i;
    end
  end
endmodule

// File: rtl/gr_pacer.sv
module gr_pacer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic active_i,
  input  logic half_i,
  output logic step_en_o
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d   = phase_q;
    step_en_o = 1'b0;
    if (!active_i) begin
      phase_d = 1'b0;
    end else if (stb_i) begin
      if (half_i) begin
        step_en_o = phase_q;
        phase_d   = ~phase_q;
      end else begin
        step_en_o = 1'b1;
        phase_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // R3: in half-rate pacing no two consecutive strobes both move the gain
  a_r3_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_o && half_i && $past(half_i) && $past(active_i)) |-> !$past(step_en_o))
    else $error("a_r3_no_back_to_back");
endmodule

// File: rtl/gr_stepper.sv
module gr_stepper
  import gr_pkg::*;
#(
  parameter int GAIN_W   = 7,
  parameter int GAIN_MAX = 119
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              step_en_i,
  input  logic              bypass_i,
  input  logic              eff_mute_i,
  input  logic [GAIN_W-1:0] eff_code_i,
  output logic [GAIN_W-1:0] code_o,
  output logic              mute_o,
  output logic              active_o
);
  localparam logic [GAIN_W-1:0] MaxCode = GAIN_W'(GAIN_MAX);

  logic [GAIN_W-1:0] code_q, code_d;
  logic              mute_q, mute_d;
  step_dir_e         dir;

  always_comb begin
    if (mute_q) begin
      dir = eff_mute_i ? DIR_HOLD : DIR_UP;
    end else if (eff_mute_i) begin
      dir = DIR_DOWN;
    end else if (eff_code_i > code_q) begin
      dir = DIR_UP;
    end else if (eff_code_i < code_q) begin
      dir = DIR_DOWN;
    end else begin
      dir = DIR_HOLD;
    end
  end

  always_comb begin
    code_d = code_q;
    mute_d = mute_q;
    if (bypass_i) begin
      code_d = eff_code_i;
      mute_d = eff_mute_i;
    end else if (step_en_i) begin
      unique case (dir)
        DIR_UP: begin
          if (mute_q) begin
            mute_d = 1'b0;
            code_d = '0;
          end else begin
            code_d = code_q + 1'b1;
          end
        end
        DIR_DOWN: begin
          if (code_q == '0) begin
            mute_d = 1'b1;
          end else begin
            code_d = code_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mute_q <= 1'b1;
    end else begin
      code_q <= code_d;
      mute_q <= mute_d;
    end
  end

  assign code_o   = code_q;
  assign mute_o   = mute_q;
  assign active_o = (dir != DIR_HOLD);

  // R10: without a strobe and with ramping on, the applied state holds
  a_r10_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(stb_i) && !$past(bypass_i)) |-> ($stable(code_q) && $stable(mute_q)))
    else $error("a_r10_hold_no_strobe");

  // R2: a ramp step never moves more than one code
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(bypass_i) && !mute_q && !$past(mute_q)) |->
      (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1 ||
       code_q == $past(code_q) - 1'b1))
    else $error("a_r2_single_step");

  // R4: leaving mute through the ramp lands on code 0
  a_r4_exit_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mute_q) && !$past(bypass_i)) |-> (code_q == '0))
    else $error("a_r4_exit_at_zero");

  // R4: entering mute through the ramp happens only from code 0
  a_r4_enter_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mute_q) && !$past(bypass_i)) |-> ($past(code_q) == '0))
    else $error("a_r4_enter_from_zero");

  // R6: the applied code never leaves the legal range
  a_r6_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= MaxCode)
    else $error("a_r6_in_range");
endmodule

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl #(
  parameter int GAIN_W   = 7,
  parameter int GAIN_MAX = 119
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_stb_i,
  input  logic [GAIN_W-1:0] tgt_code_i,
  input  logic              pace_half_i,
  input  logic              bypass_i,
  input  logic              pwrdn_req_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              mute_o,
  output logic              settled_o,
  output logic              pd_done_o
);
  logic              eff_mute;
  logic [GAIN_W-1:0] eff_code;
  logic              step_en;
  logic              active;

  gr_target_sel #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_tsel (
    .tgt_code_i (tgt_code_i),
    .pwrdn_req_i(pwrdn_req_i),
    .eff_mute_o (eff_mute),
    .eff_code_o (eff_code)
  );

  gr_pacer u_pacer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (smp_stb_i),
    .active_i (active && !bypass_i),
    .half_i   (pace_half_i),
    .step_en_o(step_en)
  );

  gr_stepper #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (smp_stb_i),
    .step_en_i (step_en),
    .bypass_i  (bypass_i),
    .eff_mute_i(eff_mute),
    .eff_code_i(eff_code),
    .code_o    (gain_o),
    .mute_o    (mute_o),
    .active_o  (active)
  );

  assign settled_o = !active;
  assign pd_done_o = pwrdn_req_i && mute_o;

  // R9: mute is only ever entered while a power-down is requested
  a_r9_mute_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute_o) |-> $past(pwrdn_req_i))
    else $error("a_r9_mute_needs_request");
endmodule

// File: tb/tb_gain_ramp_ctrl.sv
module tb_gain_ramp_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       stb;
  logic [6:0] tgt;
  logic       half, byp, pd;
  logic [6:0] gain;
  logic       mute, settled, pd_done;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  gain_ramp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_stb_i(stb), .tgt_code_i(tgt),
    .pace_half_i(half), .bypass_i(byp), .pwrdn_req_i(pd),
    .gain_o(gain), .mute_o(mute), .settled_o(settled), .pd_done_o(pd_done)
  );

  typedef struct packed {
    logic [7:0] req;
    logic [6:0] tgt;
    logic       half;
    logic       byp;
    logic       pd;
    logic [7:0] n;
    logic [6:0] egain;
    logic       emute;
    logic       eset;
    logic       epd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{8'd4,  7'd3,   1'b0, 1'b0, 1'b0, 8'd1,   7'd0,   1'b0, 1'b0, 1'b0}, // R4 leave mute at 0
    '{8'd2,  7'd3,   1'b0, 1'b0, 1'b0, 8'd2,   7'd2,   1'b0, 1'b0, 1'b0}, // R2
    '{8'd7,  7'd3,   1'b0, 1'b0, 1'b0, 8'd3,   7'd3,   1'b0, 1'b1, 1'b0}, // R7 settled
    '{8'd2,  7'd1,   1'b0, 1'b0, 1'b0, 8'd1,   7'd2,   1'b0, 1'b0, 1'b0}, // R2 downward
    '{8'd5,  7'd5,   1'b0, 1'b0, 1'b0, 8'd1,   7'd3,   1'b0, 1'b0, 1'b0}, // R5 redirect
    '{8'd3,  7'd5,   1'b1, 1'b0, 1'b0, 8'd1,   7'd3,   1'b0, 1'b0, 1'b0}, // R3 first strobe idle
    '{8'd3,  7'd5,   1'b1, 1'b0, 1'b0, 8'd1,   7'd4,   1'b0, 1'b0, 1'b0}, // R3 second strobe
    '{8'd3,  7'd5,   1'b1, 1'b0, 1'b0, 8'd2,   7'd5,   1'b0, 1'b1, 1'b0}, // R3
    '{8'd8,  7'd127, 1'b0, 1'b1, 1'b0, 8'd0,   7'd119, 1'b0, 1'b1, 1'b0}, // R8 R6
    '{8'd10, 7'd2,   1'b0, 1'b0, 1'b0, 8'd0,   7'd119, 1'b0, 1'b0, 1'b0}, // R10
    '{8'd2,  7'd2,   1'b0, 1'b0, 1'b0, 8'd4,   7'd115, 1'b0, 1'b0, 1'b0}, // R2
    '{8'd9,  7'd2,   1'b0, 1'b0, 1'b1, 8'd0,   7'd115, 1'b0, 1'b0, 1'b0}, // R9 not done yet
    '{8'd9,  7'd2,   1'b0, 1'b0, 1'b1, 8'd115, 7'd0,   1'b0, 1'b0, 1'b0}, // R9 at code 0
    '{8'd9,  7'd2,   1'b0, 1'b0, 1'b1, 8'd1,   7'd0,   1'b1, 1'b1, 1'b1}, // R9 R4 into mute
    '{8'd8,  7'd2,   1'b0, 1'b1, 1'b0, 8'd0,   7'd2,   1'b0, 1'b1, 1'b0}  // R8 out of mute
  };

  task automatic chk(input string what, input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input int req, input int g, input int m, input int s, input int p);
    chk("gain", req, int'(gain), g);
    chk("mute", req, int'(mute), m);
    chk("settled", req, int'(settled), s);
    chk("pd_done", req, int'(pd_done), p);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) stb = 1'b1;
      @(negedge clk) stb = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stb = 1'b0; tgt = 7'd0; half = 1'b0; byp = 1'b0; pd = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk_all(1, 0, 1, 0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: state after release, no strobes yet
    chk_all(1, 0, 1, 0, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tgt = TBL[i].tgt; half = TBL[i].half; byp = TBL[i].byp; pd = TBL[i].pd;
      pulses(int'(TBL[i].n));
      chk_all(int'(TBL[i].req), int'(TBL[i].egain), int'(TBL[i].emute),
              int'(TBL[i].eset), int'(TBL[i].epd));
    end

    // R6: soft ramp toward an out-of-range target stops at 119
    byp = 1'b0; half = 1'b0; tgt = 7'd125;
    pulses(118);
    chk_all(6, 119, 0, 1, 0);

    // R7: settled stays low while power-down walks away, R9 with bypass mutes at once
    pd = 1'b1;
    @(negedge clk);
    chk("settled", 7, int'(settled), 0);
    byp = 1'b1;
    @(negedge clk);
    chk_all(9, 0, 1, 1, 1);
    // R9: dropping the request clears the done flag
    pd = 1'b0; byp = 1'b0;
    #1;
    chk("pd_done", 9, int'(pd_done), 0);

    // R1: reset in the middle of operation returns to mute
    byp = 1'b1; tgt = 7'd40;
    @(negedge clk);
    chk("gain", 8, int'(gain), 40);
    byp = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk_all(1, 0, 1, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule